// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that lets a bus master reach a 64-byte internal register file through a 6-bit location pointer. It watches SCL and SDA, which arrive already synchronized to the system clock. It recognizes START, repeated START and STOP, compares the 7-bit target address, and pulls SDA low through an output-enable signal. SDA itself is an open-drain line with an external pull-up.

A write transfer first loads the pointer from the word-address byte and then stores each following data byte. A random read is a short write that sets the pointer, followed by a repeated START and a read. A current-address read skips the address phase and begins at whatever the pointer holds. The pointer keeps its value across transfers, and through reset of the control logic it returns to zero. In a read, the pointer moves forward only when the master acknowledges a byte.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset the target leaves SDA released and the pointer is 0. Reset does not clear the register file contents, so a current-address read right after reset returns the byte stored at location 0.
- R2: The first byte after a START carries the target address in bits 7:1 and the direction in bit 0 (1 = read), sent MSB first. On a match the target pulls SDA low on the ninth clock. On a mismatch it leaves SDA released, and it keeps SDA released for all later bytes until the next START.
- R3: In a write transfer, the byte after the address acknowledge is the word address. Its low 6 bits load the pointer and its upper 2 bits are ignored. The target acknowledges it.
- R4: In a write transfer, each byte after the word address is stored at the pointer and acknowledged. The pointer then increments, wrapping from 63 to 0.
- R5: After a pointer-setting write, a repeated START and a matching address with bit 0 = 1, the target transmits the byte at the pointer, MSB first.
- R6: During a read, a master ACK on the ninth clock advances the pointer by one, wrapping from 63 to 0. The next byte follows at once, and this continues until STOP.
- R7: A master NACK on the ninth clock leaves the pointer unchanged, and the target stops driving SDA.
- R8: A read that begins directly with bit 0 = 1 returns the byte at the pointer left by the previous transfer.
- R9: A START or STOP in the middle of a byte aborts that byte. A partial data byte is not stored, and the target is ready for a new address byte.
- R10: The target changes its SDA drive only while SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach is an abort in the middle of a byte. The target must drop a partially shifted data byte, yet keep the pointer that the word-address phase set a moment earlier. A second form of the same case is a repeated START cutting into a byte, where the target must fall back to address decoding. The stimulus sends only part of a data byte, bit by bit, and then either issues STOP or a repeated START with a read. A following current-address read then shows that both the pointer and the stored byte stayed unchanged.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WADR,
    ST_WACK,
    ST_WDAT,
    ST_DACK,
    ST_RDAT,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edge with SCL held high marks a bus condition
  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_regmem.sv
module i2c_regmem #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  // Storage is deliberately not reset: contents survive a control reset
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 8,
  parameter logic [6:0]  TGT_ADDR = 7'b1101000,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              we_o,
  output logic              sda_oe_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] ptr_inc;
  logic              byte_end;
  logic              ptr_load;
  logic              rd_ack_evt;
  logic              rd_nack_evt;

  assign ptr_inc     = ptr_q + 1'b1;
  assign byte_end    = scl_fall_i && (cnt_q == LAST_BIT);
  assign ptr_load    = (state_q == ST_WADR) && byte_end;
  assign rd_ack_evt  = (state_q == ST_RACK) && scl_fall_i && mack_q;
  assign rd_nack_evt = (state_q == ST_RACK) && scl_fall_i && !mack_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    ptr_d   = ptr_q;
    we_o    = 1'b0;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WADR, ST_WDAT: begin
          if (scl_rise_i) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_i};
            cnt_d = cnt_q + 1'b1;
          end
          if (byte_end) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[DATA_W-1:1] == TGT_ADDR) begin
                state_d = ST_AACK;
                rw_d    = sh_q[0];
              end else begin
                state_d = ST_IDLE;
              end
            end else if (ptr_load) begin
              ptr_d   = sh_q[ADDR_W-1:0];
              state_d = ST_WACK;
            end else begin
              we_o    = 1'b1;
              ptr_d   = ptr_inc;
              state_d = ST_DACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall_i) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RDAT;
              tx_d    = rd_data_i;
            end else begin
              state_d = ST_WADR;
            end
          end
        end
        ST_WACK, ST_DACK: begin
          if (scl_fall_i) begin
            cnt_d   = '0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise_i) begin
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              state_d = ST_RACK;
            end else begin
              tx_d = {tx_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack_d = ~sda_i;
          end
          if (rd_ack_evt) begin
            ptr_d   = ptr_inc;
            tx_d    = rd_data_i;
            cnt_d   = '0;
            state_d = ST_RDAT;
          end else if (rd_nack_evt) begin
            state_d = ST_IDLE;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      ptr_q   <= ptr_d;
    end
  end

  // Read port looks one location ahead while waiting for the master's ACK
  assign rd_addr_o = (state_q == ST_RACK) ? ptr_inc : ptr_q;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = sh_q;

  always_comb begin
    unique case (state_q)
      ST_AACK, ST_WACK, ST_DACK: sda_oe_o = 1'b1;
      ST_RDAT:                   sda_oe_o = ~tx_q[DATA_W-1];
      default:                   sda_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int         DEPTH    = 64,
  parameter int         DATA_W   = 8,
  parameter logic [6:0] TGT_ADDR = 7'b1101000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [1:0]        rst_sync_q;
  logic              rst_n_sync;
  logic              bus_start, bus_stop, scl_rise, scl_fall;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync_q[1];

  i2c_bus_cond cond_i (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (bus_start),
    .stop_o     (bus_stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  i2c_tgt_fsm #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TGT_ADDR (TGT_ADDR)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_i),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .we_o       (mem_we),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_regmem #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) mem_i (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );
endmodule

// File: rtl/i2c_regfile_chk.sv
module i2c_regfile_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start,
  input logic              stop,
  input logic              we,
  input logic              ptr_load,
  input logic              rd_ack,
  input logic              rd_nack,
  input logic [ADDR_W-1:0] ptr,
  input logic [DATA_W-1:0] shreg
);
  // R10
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  // R9
  cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start || stop) |=> !sda_oe);

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (ptr == $past(shreg[ADDR_W-1:0])));

  // R4
  write_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  // R6
  read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  // R7
  read_nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_nack |=> ((ptr == $past(ptr)) && !sda_oe));
endmodule

bind i2c_regfile_target i2c_regfile_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe_o),
  .start    (bus_start),
  .stop     (bus_stop),
  .we       (mem_we),
  .ptr_load (fsm_i.ptr_load),
  .rd_ack   (fsm_i.rd_ack_evt),
  .rd_nack  (fsm_i.rd_nack_evt),
  .ptr      (fsm_i.ptr_q),
  .shreg    (fsm_i.sh_q)
);

// File: tb/i2c_regfile_target_tb_top.sv
module i2c_regfile_target_tb_top;
  localparam int         CLK_P = 10;
  localparam int         Q     = 4;
  localparam logic [6:0] TGT   = 7'b1101000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   errors = 0;
  int   checks = 0;
  int   oe_viol = 0;
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2c_regfile_target dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  // R10 monitor: drive may not change across a high SCL sample pair
  always @(posedge clk) begin
    if (rst_n && prev_scl && m_scl && (sda_oe != prev_oe)) oe_viol++;
    prev_scl <= m_scl;
    prev_oe  <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) begin
      m_sda = v[7-i]; tick(Q);
      m_scl = 1'b1;   tick(Q);
      m_scl = 1'b0;   tick(Q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    send_bits(8, b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] b);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      m_scl = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      m_scl = 1'b0; tick(Q);
    end
    m_sda = ack ? 1'b0 : 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  // Pointer-setting write header: START, address+W, word address
  task automatic set_ptr(input logic [7:0] word, input string req);
    bit a;
    bus_start();
    wr_byte({TGT, 1'b0}, a); check(a, "R2 address ack", a, 1);
    wr_byte(word, a);        check(a, req, a, 1);
  endtask

  task automatic cur_read(input logic [7:0] exp, input string req);
    bit a;
    logic [7:0] d;
    bus_start();
    wr_byte({TGT, 1'b1}, a); check(a, "R2 read address ack", a, 1);
    rd_byte(1'b0, d);        check(d == exp, req, d, exp);
    bus_stop();
  endtask

  task automatic t_reset();
    tick(3);
    check(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);
  endtask

  task automatic t_write_burst();
    bit a;
    set_ptr(8'h05, "R3 word address ack");
    wr_byte(8'h3C, a); check(a, "R4 data ack", a, 1);
    wr_byte(8'hA5, a); check(a, "R4 data ack", a, 1);
    wr_byte(8'h81, a); check(a, "R4 data ack", a, 1);
    bus_stop();
  endtask

  task automatic t_random_read();
    bit a;
    logic [7:0] d;
    set_ptr(8'h05, "R3 word address ack");
    bus_start();
    wr_byte({TGT, 1'b1}, a); check(a, "R5 read address ack", a, 1);
    rd_byte(1'b1, d); check(d == 8'h3C, "R5 first byte", d, 8'h3C);
    rd_byte(1'b1, d); check(d == 8'hA5, "R6 sequential byte", d, 8'hA5);
    rd_byte(1'b0, d); check(d == 8'h81, "R6 sequential byte", d, 8'h81);
    bus_stop();
  endtask

  task automatic t_current_read();
    cur_read(8'h81, "R8 current read from held pointer");
    cur_read(8'h81, "R7 NACK kept pointer");
  endtask

  task automatic t_wrap();
    bit a;
    logic [7:0] d;
    set_ptr(8'hFE, "R3 word address upper bits ignored");
    wr_byte(8'h5A, a); check(a, "R4 data ack", a, 1);
    wr_byte(8'hC3, a); check(a, "R4 data ack", a, 1);
    wr_byte(8'h0F, a); check(a, "R4 data ack after wrap", a, 1);
    bus_stop();
    set_ptr(8'h3E, "R3 word address ack");
    bus_start();
    wr_byte({TGT, 1'b1}, a); check(a, "R5 read address ack", a, 1);
    rd_byte(1'b1, d); check(d == 8'h5A, "R4 stored at 62", d, 8'h5A);
    rd_byte(1'b1, d); check(d == 8'hC3, "R4 stored at 63", d, 8'hC3);
    rd_byte(1'b0, d); check(d == 8'h0F, "R6 read wrap to 0", d, 8'h0F);
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    wr_byte({7'h50, 1'b0}, a); check(!a, "R2 mismatch NACK", a, 0);
    wr_byte(8'h10, a);         check(!a, "R2 ignored byte NACK", a, 0);
    wr_byte(8'h99, a);         check(!a, "R2 ignored byte NACK", a, 0);
    bus_stop();
    cur_read(8'h0F, "R2 mismatch left pointer and data");
  endtask

  task automatic t_abort();
    bit a;
    logic [7:0] d;
    set_ptr(8'h05, "R3 word address ack");
    send_bits(4, 8'hFF);
    bus_stop();
    cur_read(8'h3C, "R9 STOP mid-byte not stored");
    set_ptr(8'h06, "R3 word address ack");
    send_bits(3, 8'h00);
    bus_start();
    wr_byte({TGT, 1'b1}, a); check(a, "R9 address after mid-byte START", a, 1);
    rd_byte(1'b0, d); check(d == 8'hA5, "R9 START mid-byte", d, 8'hA5);
    bus_stop();
  endtask

  task automatic t_reset_persist();
    rst_n = 1'b0; tick(3);
    rst_n = 1'b1; tick(5);
    check(sda_oe == 1'b0, "R1 released after second reset", sda_oe, 0);
    cur_read(8'h0F, "R1 pointer 0 and contents kept");
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    t_reset();
    t_write_burst();
    t_random_read();
    t_current_read();
    t_wrap();
    t_mismatch();
    t_abort();
    t_reset_persist();
    check(oe_viol == 0, "R10 SDA drive stable while SCL high", oe_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule